// File: doc/BRIEF.md
# Prioritized Ready Queue with Issue Selection

This block holds operations whose source operands are already available and, every cycle, picks up to four of them to start execution. Each entry carries a tag naming its reservation slot, a program sequence number, a scheduling class (ordinary, memory or long-latency), an execution kind and, for operations that need one, the index of the functional unit and the latency that unit takes.

Memory and long-latency work is pushed to the head of the queue, with the newest such entry in front. Ordinary work is kept sorted by sequence number behind all priority entries. Each cycle, the issue stage examines the entries in the first four slots, nearest the head first. Stores and operations that need no unit always leave the queue. An operation that needs a unit leaves only if that unit is neither busy nor already claimed that cycle. Losers stay in the queue in their order, ahead of everything that was not examined. Functional unit timing is outside the block and arrives as a per-unit busy vector.

Top module: `ready_issue_queue`

## Requirements
- R1: After a synchronous active-low reset the queue is empty: `enq_full` is 0 and no issue lane is valid, whatever `fu_busy` is.
- R2: An accepted entry whose class `enq_cls` is nonzero (1 memory, 2 long-latency, 3 treated the same) goes to the head of the queue, in front of every entry already queued, including earlier priority entries.
- R3: An accepted entry with class 0 is placed behind all priority entries and among ordinary entries in ascending unsigned `enq_seq` order; an equal sequence number goes behind the existing one.
- R4: Only the first four entries from the head are examined per cycle; issue lane k shows the k-th entry from the head. Entries beyond the fourth keep their order.
- R5: An entry of kind 2 or 3 (needs a unit) issues only if `fu_busy[enq_fu]` is 0 and no lane closer to the head has won the same unit in that cycle. `fu_claim` shows the units won in the cycle.
- R6: An examined entry that does not issue stays in the queue, ahead of the unexamined entries and in its previous order. A priority entry accepted in the same cycle still goes in front of it.
- R7: Issue latency is 0 for kind 0 (store), 1 for kind 1 (needs no unit), and `enq_lat` for kinds 2 and 3. Stores and kind 1 issue regardless of `fu_busy`.
- R8: With 16 entries queued, `enq_full` is 1 and an enqueue is refused and has no effect on the queue.
- R9: Issue outputs are combinational from the queue contents and `fu_busy`. An entry accepted at one clock edge can issue in the following cycle. An issued entry is removed at the next edge. A lane that is not valid shows tag 0 and latency 0.
- R10: Every accepted entry issues exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enq_valid | input | 1 | Enqueue request |
| enq_tag | input | 6 | Reservation slot tag of the entry |
| enq_seq | input | 8 | Program sequence number |
| enq_cls | input | 2 | 0 ordinary, 1 memory, 2 long-latency |
| enq_kind | input | 2 | 0 store, 1 no unit, 2/3 needs a unit |
| enq_fu | input | 2 | Functional unit index for kinds 2/3 |
| enq_lat | input | 4 | Unit latency for kinds 2/3 |
| enq_full | output | 1 | Queue holds 16 entries, enqueue refused |
| fu_busy | input | 4 | Per-unit busy flags |
| iss_valid | output | 4 | Lane k issues this cycle |
| iss_tag | output | 24 | Lane k tag at bits [6k+5:6k] |
| iss_lat | output | 16 | Lane k latency at bits [4k+3:4k] |
| fu_claim | output | 4 | Units won this cycle |

## Verification
A corrupted order inside the queue shows up at the ports as soon as the affected entries reach the first four slots. Lane positions then appear swapped in `iss_tag`, or a nearer-head entry loses a unit to a later one in `fu_claim`. A lost or duplicated entry shows up in a drain. When the full queue is released one entry per cycle, the tags come out in a fixed order, and an extra or missing lane appears within 16 cycles. A refused enqueue that leaked in is caught one cycle later, because it is a head-inserted entry that would issue at once.

// File: rtl/riq_pkg.sv
// Shared widths, encodings and the queue entry record for the ready queue.
// Assumes a single-issue enqueue port and a small number of unit kinds.
package riq_pkg;
    localparam int TAG_W    = 6;
    localparam int SEQ_W    = 8;
    localparam int LAT_W    = 4;
    localparam int FU_N     = 4;
    localparam int FU_IDX_W = $clog2(FU_N);

    typedef enum logic [1:0] {
        KIND_STORE    = 2'd0,
        KIND_PLAIN    = 2'd1,
        KIND_UNIT     = 2'd2,
        KIND_UNIT_ALT = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        CLS_ORD  = 2'd0,
        CLS_MEM  = 2'd1,
        CLS_LONG = 2'd2,
        CLS_RSVD = 2'd3
    } cls_e;

    typedef struct packed {
        logic [TAG_W-1:0]    tag;
        logic [SEQ_W-1:0]    seq;
        logic                prio;
        kind_e               kind;
        logic [FU_IDX_W-1:0] fu;
        logic [LAT_W-1:0]    lat;
    } entry_t;

    function automatic logic needs_unit(input kind_e k);
        return (k == KIND_UNIT) || (k == KIND_UNIT_ALT);
    endfunction
endpackage

// File: rtl/riq_grant.sv
// Issue selection over the head lanes: walks lanes from the head, grants
// units in lane order, and reports each lane's tag and completion latency.
// Assumes lane_ok marks lanes that hold a real entry; purely combinational,
// clk and rst_n serve only the embedded checks.
module riq_grant
    import riq_pkg::*;
#(
    parameter int ISSUE_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  entry_t [ISSUE_W-1:0]     lanes,
    input  logic   [ISSUE_W-1:0]     lane_ok,
    input  logic   [FU_N-1:0]        fu_busy,
    output logic   [ISSUE_W-1:0]     take,
    output logic   [ISSUE_W*TAG_W-1:0] tag_o,
    output logic   [ISSUE_W*LAT_W-1:0] lat_o,
    output logic   [FU_N-1:0]        claim_o
);
    logic [FU_N-1:0]               claimed;
    logic [FU_N-1:0][ISSUE_W-1:0]  win;

    // Walk lanes from the head; a unit goes to the nearest lane asking for it.
    always_comb begin
        claimed = '0;
        take    = '0;
        tag_o   = '0;
        lat_o   = '0;
        for (int k = 0; k < ISSUE_W; k++) begin
            if (lane_ok[k]) begin
                if (needs_unit(lanes[k].kind)) begin
                    if (!fu_busy[lanes[k].fu] && !claimed[lanes[k].fu]) begin
                        take[k]                  = 1'b1;
                        claimed[lanes[k].fu]     = 1'b1;
                        lat_o[k*LAT_W +: LAT_W]  = lanes[k].lat;
                    end
                end else begin
                    take[k] = 1'b1;
                    lat_o[k*LAT_W +: LAT_W] =
                        (lanes[k].kind == KIND_STORE) ? '0 : LAT_W'(1);
                end
                if (take[k]) tag_o[k*TAG_W +: TAG_W] = lanes[k].tag;
            end
        end
        claim_o = claimed;
    end

    // Per-unit view of which issuing lanes used it, for the exclusivity check.
    always_comb begin
        for (int f = 0; f < FU_N; f++)
            for (int k = 0; k < ISSUE_W; k++)
                win[f][k] = take[k] && needs_unit(lanes[k].kind)
                            && (lanes[k].fu == FU_IDX_W'(f));
    end

    for (genvar f = 0; f < FU_N; f++) begin : g_unit_chk
        AST_UNIT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(win[f])); // R5
    end

    AST_BUSY_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_o & fu_busy) == '0); // R5

    for (genvar k = 0; k < ISSUE_W; k++) begin : g_idle_chk
        AST_IDLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
            !take[k] |-> (tag_o[k*TAG_W +: TAG_W] == '0 && lat_o[k*LAT_W +: LAT_W] == '0)); // R9
    end
endmodule

// File: rtl/riq_order.sv
// Ordered entry storage: slot 0 is the head. Each cycle it removes the
// lanes that issued, closes the gaps, then inserts the accepted entry at
// the head (priority) or at its sequence position among ordinary entries.
// Assumes enq_acc is only raised while count < DEPTH.
module riq_order
    import riq_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int ISSUE_W = 4,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ISSUE_W-1:0]    take,
    input  logic                  enq_acc,
    input  entry_t                enq_ent,
    output entry_t [ISSUE_W-1:0]  head,
    output logic   [ISSUE_W-1:0]  head_ok,
    output logic   [CNT_W-1:0]    count
);
    entry_t [DEPTH-1:0] q;
    entry_t [DEPTH-1:0] comp;
    entry_t [DEPTH-1:0] nxt;
    logic   [DEPTH-1:0] rm;
    int                 kept;
    int                 pos;

    // Expose the head lanes and which of them hold entries.
    always_comb begin
        for (int k = 0; k < ISSUE_W; k++) begin
            head[k]    = q[k];
            head_ok[k] = (k < int'(count));
        end
    end

    // Drop issued lanes and close the gaps, keeping order.
    always_comb begin
        rm               = '0;
        rm[ISSUE_W-1:0]  = take;
        comp             = '0;
        kept             = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (i < int'(count) && !rm[i]) begin
                comp[kept] = q[i];
                kept       = kept + 1;
            end
        end
    end

    // Find the insertion slot: head for priority, else by sequence number.
    always_comb begin
        pos = 0;
        if (!enq_ent.prio) begin
            for (int j = 0; j < DEPTH; j++)
                if (j < kept && (comp[j].prio || comp[j].seq <= enq_ent.seq))
                    pos = pos + 1;
        end
    end

    // Shift the compacted list open at the insertion slot.
    always_comb begin
        nxt[0] = (enq_acc && pos == 0) ? enq_ent : comp[0];
        for (int k = 1; k < DEPTH; k++) begin
            if (!enq_acc || k < pos) nxt[k] = comp[k];
            else if (k == pos)       nxt[k] = enq_ent;
            else                     nxt[k] = comp[k-1];
        end
    end

    // State update with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            count <= '0;
        end else begin
            q     <= nxt;
            count <= CNT_W'(kept) + CNT_W'(enq_acc);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count <= CNT_W'(DEPTH)
                  && count == $past(count) + CNT_W'($past(enq_acc))
                              - CNT_W'($countones($past(take))))); // R8

    AST_PRIO_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_acc && enq_ent.prio) |=> (q[0].tag == $past(enq_ent.tag))); // R2

    for (genvar j = 0; j < DEPTH - 1; j++) begin : g_order_chk
        AST_ORD_SORTED: assert property (@(posedge clk) disable iff (!rst_n)
            (j + 1 < int'(count) && !q[j].prio)
                |-> (!q[j+1].prio && q[j].seq <= q[j+1].seq)); // R3
    end
endmodule

// File: rtl/ready_issue_queue.sv
// Top of the prioritized ready queue: packs the enqueue fields into an
// entry, refuses enqueue when full, and ties storage to issue selection.
// Assumes one enqueue per cycle and an external per-unit busy vector.
module ready_issue_queue
    import riq_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int ISSUE_W = 4,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enq_valid,
    input  logic [TAG_W-1:0]           enq_tag,
    input  logic [SEQ_W-1:0]           enq_seq,
    input  logic [1:0]                 enq_cls,
    input  logic [1:0]                 enq_kind,
    input  logic [FU_IDX_W-1:0]        enq_fu,
    input  logic [LAT_W-1:0]           enq_lat,
    output logic                       enq_full,
    input  logic [FU_N-1:0]            fu_busy,
    output logic [ISSUE_W-1:0]         iss_valid,
    output logic [ISSUE_W*TAG_W-1:0]   iss_tag,
    output logic [ISSUE_W*LAT_W-1:0]   iss_lat,
    output logic [FU_N-1:0]            fu_claim
);
    entry_t                ent;
    entry_t [ISSUE_W-1:0]  head;
    logic   [ISSUE_W-1:0]  head_ok;
    logic   [ISSUE_W-1:0]  take;
    logic   [CNT_W-1:0]    count;
    logic                  enq_acc;

    // Build the entry record and decide whether the enqueue is accepted.
    always_comb begin
        ent.tag  = enq_tag;
        ent.seq  = enq_seq;
        ent.prio = (cls_e'(enq_cls) != CLS_ORD);
        ent.kind = kind_e'(enq_kind);
        ent.fu   = enq_fu;
        ent.lat  = enq_lat;
        enq_full = (count == CNT_W'(DEPTH));
        enq_acc  = enq_valid && !enq_full;
    end

    riq_order #(.DEPTH(DEPTH), .ISSUE_W(ISSUE_W)) u_order (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .enq_acc (enq_acc),
        .enq_ent (ent),
        .head    (head),
        .head_ok (head_ok),
        .count   (count)
    );

    riq_grant #(.ISSUE_W(ISSUE_W)) u_grant (
        .clk     (clk),
        .rst_n   (rst_n),
        .lanes   (head),
        .lane_ok (head_ok),
        .fu_busy (fu_busy),
        .take    (take),
        .tag_o   (iss_tag),
        .lat_o   (iss_lat),
        .claim_o (fu_claim)
    );

    assign iss_valid = take;
endmodule

// File: tb/ready_issue_queue_test.sv
`timescale 1ns/1ps
module ready_issue_queue_test;
    typedef struct packed {
        logic        en;
        logic [5:0]  tag;
        logic [7:0]  seq;
        logic [1:0]  cls;
        logic [1:0]  kind;
        logic [1:0]  fu;
        logic [3:0]  lat;
        logic [3:0]  busy;
        logic [3:0]  ev;
        logic [23:0] etag;
        logic [15:0] elat;
        logic [3:0]  eclaim;
        logic [3:0]  rq;
    } vec_t;

    // Outputs are those of the queue state before the edge that takes the enqueue.
    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 6'd1, 8'd10, 2'd0, 2'd2, 2'd0, 4'd3, 4'hF, 4'h0, 24'd0, 16'd0, 4'h0, 4'd3},  // R3
        '{1'b1, 6'd2, 8'd5,  2'd0, 2'd2, 2'd1, 4'd4, 4'hF, 4'h0, 24'd0, 16'd0, 4'h0, 4'd3},
        '{1'b1, 6'd3, 8'd20, 2'd1, 2'd2, 2'd2, 4'd2, 4'hF, 4'h0, 24'd0, 16'd0, 4'h0, 4'd2},  // R2
        '{1'b1, 6'd4, 8'd21, 2'd2, 2'd2, 2'd3, 4'd5, 4'hF, 4'h0, 24'd0, 16'd0, 4'h0, 4'd2},
        '{1'b1, 6'd5, 8'd7,  2'd0, 2'd2, 2'd0, 4'd6, 4'hF, 4'h0, 24'd0, 16'd0, 4'h0, 4'd3},
        '{1'b0, 6'd0, 8'd0,  2'd0, 2'd0, 2'd0, 4'd0, 4'h0, 4'hF,
          {6'd5, 6'd2, 6'd3, 6'd4}, {4'd6, 4'd4, 4'd2, 4'd5}, 4'hF, 4'd4},                  // R4
        '{1'b0, 6'd0, 8'd0,  2'd0, 2'd0, 2'd0, 4'd0, 4'h0, 4'h1,
          {6'd0, 6'd0, 6'd0, 6'd1}, {4'd0, 4'd0, 4'd0, 4'd3}, 4'h1, 4'd4},
        '{1'b1, 6'd6, 8'd30, 2'd0, 2'd2, 2'd0, 4'd2, 4'hF, 4'h0, 24'd0, 16'd0, 4'h0, 4'd5},  // R5
        '{1'b1, 6'd7, 8'd31, 2'd0, 2'd2, 2'd0, 4'd3, 4'hF, 4'h0, 24'd0, 16'd0, 4'h0, 4'd5},
        '{1'b1, 6'd8, 8'd32, 2'd0, 2'd0, 2'd0, 4'd9, 4'hF, 4'h0, 24'd0, 16'd0, 4'h0, 4'd7},  // R7
        '{1'b0, 6'd0, 8'd0,  2'd0, 2'd0, 2'd0, 4'd0, 4'h0, 4'h5,
          {6'd0, 6'd8, 6'd0, 6'd6}, {4'd0, 4'd0, 4'd0, 4'd2}, 4'h1, 4'd5},
        '{1'b0, 6'd0, 8'd0,  2'd0, 2'd0, 2'd0, 4'd0, 4'h1, 4'h0, 24'd0, 16'd0, 4'h0, 4'd6},  // R6
        '{1'b1, 6'd9, 8'd40, 2'd0, 2'd1, 2'd0, 4'd0, 4'h1, 4'h0, 24'd0, 16'd0, 4'h0, 4'd6},
        '{1'b0, 6'd0, 8'd0,  2'd0, 2'd0, 2'd0, 4'd0, 4'h0, 4'h3,
          {6'd0, 6'd0, 6'd9, 6'd7}, {4'd0, 4'd0, 4'd1, 4'd3}, 4'h1, 4'd7},
        '{1'b1, 6'd10, 8'd50, 2'd1, 2'd2, 2'd1, 4'd2, 4'hF, 4'h0, 24'd0, 16'd0, 4'h0, 4'd2},
        '{1'b1, 6'd11, 8'd51, 2'd2, 2'd2, 2'd2, 4'd7, 4'hF, 4'h0, 24'd0, 16'd0, 4'h0, 4'd2},
        '{1'b1, 6'd12, 8'd52, 2'd0, 2'd1, 2'd0, 4'd0, 4'hF, 4'h0, 24'd0, 16'd0, 4'h0, 4'd3},
        '{1'b1, 6'd13, 8'd53, 2'd1, 2'd2, 2'd1, 4'd2, 4'h4, 4'h6,
          {6'd0, 6'd12, 6'd10, 6'd0}, {4'd0, 4'd1, 4'd2, 4'd0}, 4'h2, 4'd6},
        '{1'b0, 6'd0, 8'd0,  2'd0, 2'd0, 2'd0, 4'd0, 4'h0, 4'h3,
          {6'd0, 6'd0, 6'd11, 6'd13}, {4'd0, 4'd0, 4'd7, 4'd2}, 4'h6, 4'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        enq_valid;
    logic [5:0]  enq_tag;
    logic [7:0]  enq_seq;
    logic [1:0]  enq_cls;
    logic [1:0]  enq_kind;
    logic [1:0]  enq_fu;
    logic [3:0]  enq_lat;
    logic        enq_full;
    logic [3:0]  fu_busy;
    logic [3:0]  iss_valid;
    logic [23:0] iss_tag;
    logic [15:0] iss_lat;
    logic [3:0]  fu_claim;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    ready_issue_queue uut (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_tag(enq_tag),
        .enq_seq(enq_seq), .enq_cls(enq_cls), .enq_kind(enq_kind),
        .enq_fu(enq_fu), .enq_lat(enq_lat), .enq_full(enq_full),
        .fu_busy(fu_busy), .iss_valid(iss_valid), .iss_tag(iss_tag),
        .iss_lat(iss_lat), .fu_claim(fu_claim)
    );

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic drive(input logic en, input logic [5:0] tg, input logic [7:0] sq,
                         input logic [1:0] cl, input logic [1:0] kd,
                         input logic [1:0] f, input logic [3:0] lt);
        enq_valid = en; enq_tag = tg; enq_seq = sq;
        enq_cls = cl; enq_kind = kd; enq_fu = f; enq_lat = lt;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        fu_busy = 4'h0;
        drive(1'b0, 6'd0, 8'd0, 2'd0, 2'd0, 2'd0, 4'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: empty after reset even with all units free
        chk("R1", "full", {31'd0, enq_full}, 32'd0);
        chk("R1", "valid", {28'd0, iss_valid}, 32'd0);

        // Vector table: ordering, issue limit, contention, requeue, latencies
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i].en, VEC[i].tag, VEC[i].seq, VEC[i].cls,
                  VEC[i].kind, VEC[i].fu, VEC[i].lat);
            fu_busy = VEC[i].busy;
            #1;
            chk($sformatf("R%0d v%0d", VEC[i].rq, i), "valid", {28'd0, iss_valid}, {28'd0, VEC[i].ev});
            chk($sformatf("R%0d v%0d", VEC[i].rq, i), "tag",   {8'd0, iss_tag},    {8'd0, VEC[i].etag});
            chk($sformatf("R%0d v%0d", VEC[i].rq, i), "lat",   {16'd0, iss_lat},   {16'd0, VEC[i].elat});
            chk($sformatf("R%0d v%0d", VEC[i].rq, i), "claim", {28'd0, fu_claim},  {28'd0, VEC[i].eclaim});
        end

        // R8: fill with 16 unit entries while every unit is busy
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            fu_busy = 4'hF;
            drive(1'b1, 6'(20 + i), 8'(i), 2'd0, 2'd2, 2'd0, 4'd1);
        end
        @(negedge clk);
        drive(1'b1, 6'd63, 8'd0, 2'd1, 2'd1, 2'd0, 4'd0);
        #1;
        chk("R8", "full", {31'd0, enq_full}, 32'd1);
        chk("R8", "valid", {28'd0, iss_valid}, 32'd0);
        @(negedge clk);
        drive(1'b0, 6'd0, 8'd0, 2'd0, 2'd0, 2'd0, 4'd0);
        #1;
        // A leaked head entry of kind 1 would issue at once on lane 0
        chk("R8", "refused", {28'd0, iss_valid}, 32'd0);
        chk("R8", "still_full", {31'd0, enq_full}, 32'd1);

        // R10: drain one per cycle, in sequence order, each exactly once
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            fu_busy = 4'h0;
            #1;
            chk("R10", "drain_valid", {28'd0, iss_valid}, 32'd1);
            chk("R10", "drain_tag", {8'd0, iss_tag}, 32'(20 + c));
        end
        @(negedge clk);
        #1;
        chk("R10", "empty_valid", {28'd0, iss_valid}, 32'd0);
        chk("R10", "empty_full", {31'd0, enq_full}, 32'd0);

        // R1: reset in the middle of operation discards queued entries
        @(negedge clk);
        fu_busy = 4'hF;
        drive(1'b1, 6'd40, 8'd1, 2'd0, 2'd1, 2'd0, 4'd0);
        @(negedge clk);
        drive(1'b1, 6'd41, 8'd2, 2'd2, 2'd2, 2'd1, 4'd3);
        @(negedge clk);
        drive(1'b0, 6'd0, 8'd0, 2'd0, 2'd0, 2'd0, 4'd0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        fu_busy = 4'h0;
        #1;
        chk("R1", "post_reset_valid", {28'd0, iss_valid}, 32'd0);
        chk("R1", "post_reset_full", {31'd0, enq_full}, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule